// File: doc/BRIEF.md
# DDCMP Synchronous Transmit Framer

This block turns DDCMP messages into a bit-serial stream for a synchronous line. While it is enabled and has no message to send, it keeps the line busy with fill. The fill is either a repeating pair of programmable sync characters or a repeating idle byte, chosen by a mode pin. Messages arrive one byte at a time over a valid/ready stream. The first six bytes of a message are its header. Any bytes after the header form the data field. The stream's `msg_last` flag marks the final byte of the message.

A message starts only when the fill unit on the line has finished. The block then sends one sync pair, the header and a CRC16 over the header. If there is a data field, it follows with its own CRC16. One bit leaves per cycle in which the transmit clock enable is high. Bytes go out least significant bit first. The line can be coded NRZ or NRZI.

Back-pressure: `msg_ready` is a single-cycle pulse. It rises only in a `bit_en` cycle that ends a byte, and only when the framer needs the next message byte at that point. A byte is taken when `msg_valid` and `msg_ready` are both high. Within a message, the source must have each byte valid when the pulse comes. A pulse that finds `msg_valid` low abandons the message.

Top module: `ddcmp_tx_framer`

## Requirements
- R1: While `enable` is low, `tx_line` sits at 1 and `msg_ready` stays low. After `enable` rises, the first unit sent is always fill, even if a message is already waiting.
- R2: With `fill_idle`=0, fill is `sync1` followed by `sync2`. This two-byte unit repeats.
- R3: With `fill_idle`=1, fill is the byte 8'hFF. This one-byte unit repeats.
- R4: A message that becomes valid while fill is running starts at the first fill-unit boundary the line reaches after `msg_valid` is seen high.
- R5: Every message is preceded by exactly one `sync1`, `sync2` pair.
- R6: Each byte is sent least significant bit first. One bit is sent per `bit_en` cycle. `tx_line` is registered and shows each bit from the clock edge that samples `bit_en`.
- R7: After the six header bytes come two CRC bytes, low byte first. The CRC is CRC16 with polynomial x^16+x^15+x^2+1, processed LSB-first in reflected form (0xA001), preset to 0, and computed over the header only.
- R8: If the sixth header byte is not marked last, data bytes follow until a byte marked last. Then comes a CRC over the data bytes only, with the register restarted from 0, sent low byte first.
- R9: `msg_last` on header bytes one to five is ignored. `msg_last` on the sixth header byte means the message has no data field.
- R10: `msg_ready` is high only in a `bit_en` cycle that ends a byte, and only when the next byte of the message is due.
- R11: If a `msg_ready` pulse finds `msg_valid` low, the message is dropped without any CRC. Fill starts with the very next byte.
- R12: With `nrzi_en`=1, a 0 bit toggles the line and a 1 bit holds it. Coding starts from line level 1. With `nrzi_en`=0, the line carries the bit itself.
- R13: If another message is valid when the last CRC byte ends, its sync pair follows at once with no fill in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Transmitter enable |
| fill_idle | input | 1 | Fill select: 0 = sync pairs, 1 = idle byte |
| nrzi_en | input | 1 | Line code select: 0 = NRZ, 1 = NRZI |
| sync1 | input | 8 | First sync character |
| sync2 | input | 8 | Second sync character |
| bit_en | input | 1 | Transmit clock enable, one bit per high cycle |
| msg_valid | input | 1 | Message byte valid |
| msg_ready | output | 1 | Message byte accepted this cycle when valid |
| msg_data | input | 8 | Message byte |
| msg_last | input | 1 | Marks the final byte of the message |
| tx_line | output | 1 | Coded serial line output |

## Verification
Two things can happen in the same `bit_en` cycle: a fill unit, or the final CRC byte of a message, can end in the very cycle where a new message's valid is first sampled. The bench provokes this in two ways. It raises `msg_valid` after random delays while `bit_en` toggles at random. It also presents a message immediately after the previous one. For each message, the bench records how many bits had been sent when valid rose, then computes the boundary where the sync pair must start. It compares that boundary with the bit position of the first accepted header byte.

// File: rtl/ddcmp_tx_pkg.sv
package ddcmp_tx_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

  // Kind of byte currently held in the shift register.
  typedef enum logic [3:0] {
    U_OFF,
    U_FILL1,
    U_FILL2,
    U_IDLE,
    U_PRE1,
    U_PRE2,
    U_HDR,
    U_HCRC0,
    U_HCRC1,
    U_DATA,
    U_DCRC0,
    U_DCRC1
  } unit_e;

  // One byte through the reflected CRC16, LSB first.
  function automatic logic [CRC_W-1:0] crc16_byte(input logic [CRC_W-1:0] c_in,
                                                 input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/ddcmp_tx_shifter.sv
module ddcmp_tx_shifter
  import ddcmp_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bit_en,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              bit_out,
  output logic              byte_end
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  assign bit_out  = sh[0];
  assign byte_end = active && bit_en && (cnt == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= load_byte;
      cnt <= '0;
    end else if (active && bit_en) begin
      sh  <= sh >> 1;
      cnt <= cnt + 1'b1;
    end
  end

  // R6: the bit position only moves on a transmit clock enable
  p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !load) |=> $stable(cnt));

endmodule

// File: rtl/ddcmp_line_coder.sv
module ddcmp_line_coder (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_en,
  input  logic nrzi,
  input  logic bit_in,
  output logic line
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line <= 1'b1;
    end else if (!active) begin
      line <= 1'b1;
    end else if (bit_en) begin
      if (nrzi) line <= bit_in ? line : ~line;
      else      line <= bit_in;
    end
  end

  // R12: NRZI holds on a one and flips on a zero
  p_nrzi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_en && nrzi && bit_in) |=> $stable(line));
  p_nrzi_flip_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_en && nrzi && !bit_in) |=> (line != $past(line)));
  // R1: idle transmitter parks the line at mark
  p_mark_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> line);

endmodule

// File: rtl/ddcmp_tx_seq.sv
module ddcmp_tx_seq
  import ddcmp_tx_pkg::*;
#(
  parameter int              HDR_BYTES = 6,
  parameter logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fill_idle,
  input  logic [BYTE_W-1:0] sync1,
  input  logic [BYTE_W-1:0] sync2,
  input  logic              bit_en,
  input  logic              byte_end,
  input  logic              msg_valid,
  input  logic [BYTE_W-1:0] msg_data,
  input  logic              msg_last,
  output logic              msg_ready,
  output logic              active,
  output logic              load,
  output logic [BYTE_W-1:0] load_byte
);

  localparam int HC_W = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;

  unit_e             state, nxt;
  logic [HC_W-1:0]   hcnt;
  logic [CRC_W-1:0]  crc;
  logic              last_q;
  logic              need, bound, take;
  unit_e             fill_st;
  logic [BYTE_W-1:0] fill_b;

  assign active  = enable && (state != U_OFF);
  assign fill_st = fill_idle ? U_IDLE : U_FILL1;
  assign fill_b  = fill_idle ? IDLE_BYTE : sync1;
  assign msg_ready = need;

  always_comb begin
    nxt       = state;
    load      = 1'b0;
    load_byte = fill_b;
    need      = 1'b0;
    bound     = 1'b0;
    take      = 1'b0;
    if (!enable) begin
      nxt = U_OFF;
    end else if (state == U_OFF) begin
      load = 1'b1;
      nxt  = fill_st;
    end else if (byte_end) begin
      load = 1'b1;
      case (state)
        U_FILL1: begin nxt = U_FILL2; load_byte = sync2; end
        U_PRE1:  begin nxt = U_PRE2;  load_byte = sync2; end
        U_PRE2:  need = 1'b1;
        U_HDR: begin
          if (hcnt == HC_W'(HDR_BYTES-1)) begin
            nxt = U_HCRC0; load_byte = crc[7:0];
          end else begin
            need = 1'b1;
          end
        end
        U_HCRC0: begin nxt = U_HCRC1; load_byte = crc[15:8]; end
        U_HCRC1: begin
          if (last_q) bound = 1'b1;
          else        need  = 1'b1;
        end
        U_DATA: begin
          if (last_q) begin nxt = U_DCRC0; load_byte = crc[7:0]; end
          else        need = 1'b1;
        end
        U_DCRC0: begin nxt = U_DCRC1; load_byte = crc[15:8]; end
        default: bound = 1'b1;
      endcase
      if (bound && msg_valid) begin
        nxt = U_PRE1; load_byte = sync1;
      end else if (need && msg_valid) begin
        take      = 1'b1;
        load_byte = msg_data;
        nxt       = (state == U_HCRC1 || state == U_DATA) ? U_DATA : U_HDR;
      end else if (bound || need) begin
        nxt = fill_st; load_byte = fill_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= U_OFF;
      hcnt   <= '0;
      crc    <= '0;
      last_q <= 1'b0;
    end else begin
      state <= nxt;
      if (take) begin
        last_q <= msg_last;
        if (state == U_HDR) begin
          hcnt <= hcnt + 1'b1;
          crc  <= crc16_byte(crc, msg_data);
        end else if (state == U_DATA) begin
          crc  <= crc16_byte(crc, msg_data);
        end else begin
          hcnt <= '0;
          crc  <= crc16_byte('0, msg_data);
        end
      end
    end
  end

  // R10: ready only on a transmit clock enable
  p_ready_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> bit_en);
  // R10: an accepted byte becomes the next header or data byte
  p_take_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ready && msg_valid && enable) |=> (state == U_HDR || state == U_DATA));
  // R11: an unanswered ready drops back to fill
  p_abort_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_ready && !msg_valid && enable) |=> (state == U_FILL1 || state == U_IDLE));
  // R2: a sync fill unit is always a pair
  p_fill_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == U_FILL1 && byte_end && enable) |=> (state == U_FILL2));

endmodule

// File: rtl/ddcmp_tx_framer.sv
module ddcmp_tx_framer
  import ddcmp_tx_pkg::*;
#(
  parameter int                HDR_BYTES = 6,
  parameter logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              fill_idle,
  input  logic              nrzi_en,
  input  logic [BYTE_W-1:0] sync1,
  input  logic [BYTE_W-1:0] sync2,
  input  logic              bit_en,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [BYTE_W-1:0] msg_data,
  input  logic              msg_last,
  output logic              tx_line
);

  logic              active, load, byte_end, bit_out;
  logic [BYTE_W-1:0] load_byte;

  ddcmp_tx_seq #(
    .HDR_BYTES (HDR_BYTES),
    .IDLE_BYTE (IDLE_BYTE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .fill_idle (fill_idle),
    .sync1     (sync1),
    .sync2     (sync2),
    .bit_en    (bit_en),
    .byte_end  (byte_end),
    .msg_valid (msg_valid),
    .msg_data  (msg_data),
    .msg_last  (msg_last),
    .msg_ready (msg_ready),
    .active    (active),
    .load      (load),
    .load_byte (load_byte)
  );

  ddcmp_tx_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .bit_en    (bit_en),
    .load      (load),
    .load_byte (load_byte),
    .bit_out   (bit_out),
    .byte_end  (byte_end)
  );

  ddcmp_line_coder u_coder (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .bit_en (bit_en),
    .nrzi   (nrzi_en),
    .bit_in (bit_out),
    .line   (tx_line)
  );

endmodule

// File: tb/test_ddcmp_tx_framer.sv
module test_ddcmp_tx_framer;

  localparam int CLK_PERIOD = 10;
  localparam int MAXB       = 16384;
  localparam int WATCHDOG   = 100000;
  localparam int ABORT_AT   = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, fill_idle = 1'b0, nrzi_en = 1'b0;
  logic [7:0] sync1 = 8'h96, sync2 = 8'h69;
  logic       bit_en = 1'b0;
  logic       msg_valid = 1'b0, msg_last = 1'b0;
  logic [7:0] msg_data = 8'h00;
  logic       msg_ready, tx_line;

  int checks = 0, errors = 0;
  bit rx [MAXB];
  int nbits = 0;
  logic lvl = 1'b1;
  logic prev_en = 1'b0;

  int         hstart [4];
  int         vbits  [4];
  int         ndat   [4];
  bit         abrt   [4];
  bit         early  [4];
  logic [7:0] mb     [4][32];

  ddcmp_tx_framer i_ddcmp_tx_framer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fill_idle(fill_idle),
    .nrzi_en(nrzi_en), .sync1(sync1), .sync2(sync2), .bit_en(bit_en),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_data(msg_data),
    .msg_last(msg_last), .tx_line(tx_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // random transmit clock enable
  initial begin
    void'($urandom(32'd4711));
    forever begin
      @(negedge clk);
      bit_en = (($urandom % 4) != 0);
    end
  end

  // monitor: record one decoded bit after each enabled tick
  initial forever begin
    @(posedge clk);
    if (bit_en && enable && prev_en) begin
      prev_en = enable;
      #1;
      if (nbits < MAXB) begin
        rx[nbits] = nrzi_en ? (tx_line == lvl) : tx_line;
        nbits++;
      end
      lvl = tx_line;
    end else begin
      prev_en = enable;
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [7:0] gb(input int p);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[k] = (p + k < nbits) ? rx[p+k] : 1'b0;
    return b;
  endfunction

  function automatic logic [15:0] crc_ref(input int m, input int from, input int cnt);
    logic [15:0] c;
    logic fb;
    c = 16'h0000;
    for (int i = 0; i < cnt; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ mb[m][from+i][b];
        c = c >> 1;
        if (fb) c = c ^ 16'hA001;
      end
    return c;
  endfunction

  task automatic send_msg(input int m);
    int total;
    total = 6 + ndat[m];
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (i == 0) vbits[m] = nbits;
      if (abrt[m] && i == ABORT_AT) begin
        msg_valid = 1'b0;
        @(posedge clk);
        while (!msg_ready) @(posedge clk);
        break;
      end
      msg_valid = 1'b1;
      msg_data  = mb[m][i];
      msg_last  = (i == total - 1) || (early[m] && i == 2);
      @(posedge clk);
      while (!msg_ready) @(posedge clk);
      chk(bit_en == 1'b1, "R10 ready outside tick", int'(bit_en), 1);
      if (i == 0) hstart[m] = nbits + 1;
    end
    @(negedge clk);
    msg_valid = 1'b0;
    msg_last  = 1'b0;
  endtask

  task automatic check_fill(input int from, input int upto, input string tag);
    for (int p = from; p < upto; p += 8) begin
      logic [7:0] e;
      e = fill_idle ? 8'hFF : ((((p - from) / 8) % 2) != 0 ? sync2 : sync1);
      chk(gb(p) == e, tag, int'(gb(p)), int'(e));
    end
  endtask

  task automatic check_session(input int nm);
    int seg, u, pre, ex, taken, p;
    string ftag;
    logic [15:0] c;
    seg = 0;
    u = fill_idle ? 8 : 16;
    ftag = fill_idle ? "R3 idle fill" : "R2 sync fill";
    for (int m = 0; m < nm; m++) begin
      pre = hstart[m] - 16;
      ex  = (vbits[m] < seg) ? seg : seg + (((vbits[m] - seg) / u) + 1) * u;
      if (m > 0 && vbits[m] < seg) chk(pre == ex, "R13 back-to-back start", pre, ex);
      else                         chk(pre == ex, "R4 start at unit boundary", pre, ex);
      if (m > 0 && abrt[m-1]) check_fill(seg, pre, "R11 fill after abandon");
      else if (m == 0)        check_fill(seg, pre, "R1 first unit is fill");
      else                    check_fill(seg, pre, ftag);
      chk(gb(pre) == sync1, "R5 pre sync1", int'(gb(pre)), int'(sync1));
      chk(gb(pre + 8) == sync2, "R5 pre sync2", int'(gb(pre + 8)), int'(sync2));
      taken = abrt[m] ? ABORT_AT : 6;
      for (int i = 0; i < taken; i++)
        chk(gb(hstart[m] + 8*i) == mb[m][i], "R6 header byte", int'(gb(hstart[m] + 8*i)), int'(mb[m][i]));
      if (abrt[m]) begin
        seg = hstart[m] + 8*ABORT_AT;
        continue;
      end
      p = hstart[m] + 48;
      c = crc_ref(m, 0, 6);
      chk(gb(p) == c[7:0], "R7 header crc low", int'(gb(p)), int'(c[7:0]));
      chk(gb(p + 8) == c[15:8], "R7 header crc high", int'(gb(p + 8)), int'(c[15:8]));
      p += 16;
      if (ndat[m] > 0) begin
        for (int i = 0; i < ndat[m]; i++)
          chk(gb(p + 8*i) == mb[m][6+i], early[m] ? "R9 data after early last" : "R8 data byte",
              int'(gb(p + 8*i)), int'(mb[m][6+i]));
        p += 8 * ndat[m];
        c = crc_ref(m, 6, ndat[m]);
        chk(gb(p) == c[7:0], "R8 data crc low", int'(gb(p)), int'(c[7:0]));
        chk(gb(p + 8) == c[15:8], "R8 data crc high", int'(gb(p + 8)), int'(c[15:8]));
        p += 16;
      end
      seg = p;
    end
    chk(nbits >= seg + u, "R6 bit count after last frame", nbits, seg + u);
    check_fill(seg, seg + u, nrzi_en ? "R12 trailing fill under NRZI" : "R12 trailing fill under NRZ");
  endtask

  task automatic run_session(input bit fi, input bit nz, input int abort_m);
    int dly;
    @(negedge clk);
    enable    = 1'b0;
    fill_idle = fi;
    nrzi_en   = nz;
    sync1     = 8'($urandom);
    sync2     = 8'($urandom);
    repeat (4) @(negedge clk);
    chk(tx_line == 1'b1, "R1 line parked while disabled", int'(tx_line), 1);
    chk(msg_ready == 1'b0, "R1 ready low while disabled", int'(msg_ready), 0);
    nbits = 0;
    lvl   = 1'b1;
    enable = 1'b1;
    for (int m = 0; m < 4; m++) begin
      ndat[m]  = (m == 3) ? 0 : 1 + int'($urandom % 10);
      early[m] = (m == 1);
      abrt[m]  = (m == abort_m);
      for (int i = 0; i < 32; i++) mb[m][i] = 8'($urandom);
      dly = (m == 1) ? 0 : int'($urandom % 50);
      if (dly > 0) repeat (dly) @(negedge clk);
      send_msg(m);
    end
    repeat (300) @(negedge clk);
    check_session(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1, "R1 reset line level", int'(tx_line), 1);
    chk(msg_ready == 1'b0, "R1 reset ready", int'(msg_ready), 0);
    rst_n = 1'b1;
    run_session(1'b0, 1'b0, 2);
    run_session(1'b1, 1'b1, 5);
    run_session(1'b0, 1'b1, 0);
    run_session(1'b1, 1'b0, 2);
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_line == 1'b1, "R1 line after disable", int'(tx_line), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule